// File: doc/BRIEF.md
# Embedded Flash Controller Emulator

This block stands in for an on-chip flash controller so that a flash-update engine can be exercised against realistic handshakes. It offers two slave ports. The first is a control and status port with a single address bit. Address 0 returns the status word and address 1 takes the control word. The second is a word-addressed data port with read and write strobes, a waitrequest and a readdatavalid. A small array of `NUM_SECTORS` x `SECTOR_WORDS` 32-bit words takes the place of the image region. It comes out of reset fully erased and write-protected.

A sequencer with six named states drives the timing. `S_IDLE` accepts new work. `S_RD_WAIT` counts out the read latency. `S_RD_POLL` reports read-busy until the third status poll. `S_WR_PROG` holds waitrequest while a write programs. `S_ER_ARM` waits for the first status poll after an erase request. `S_ER_RUN` reports erase-busy until the erase time runs out. The transitions are:

- `S_IDLE`->`S_RD_WAIT` on a data read.
- `S_IDLE`->`S_WR_PROG` on a data write.
- `S_IDLE`->`S_ER_ARM` on an accepted erase request.
- `S_RD_WAIT`->`S_RD_POLL` when readdatavalid fires.
- `S_RD_POLL`->`S_IDLE` on the third status poll.
- `S_WR_PROG`->`S_IDLE` on commit, or when the write strobe is withdrawn.
- `S_ER_ARM`->`S_ER_RUN` on the first status poll.
- `S_ER_RUN`->`S_IDLE` when the erase count expires.

Read latency, write time and erase time are parameters in clock cycles, so tests can use short runs.

Top module: `flash_ctl_emu`

## Requirements
- R1: After reset the status word reads 0x0000001C (idle, all three results good). The control word reads 0x07700000 (protect field 111, sector field 111). Every storage word reads 0xFFFFFFFF. readdatavalid and waitrequest are low.
- R2: Status bits [1:0] give the activity: 00 idle, 01 erase busy, 10 write busy, 11 read busy. Bit 2 is the last read result, bit 3 the last write result and bit 4 the last erase result; 1 means success and 0 means failure. Bits [31:5] read 0.
- R3: A control-port read updates the read data on the clock edge that samples the strobe. The value then holds until the next control-port read.
- R4: A data read sampled at edge k raises readdatavalid for exactly one cycle, starting at edge k+`READ_LATENCY`. Read data carries the word only in that cycle and is zero otherwise.
- R5: After readdatavalid, the first two status polls return busy code 11 and the third returns 00. Status reads made before readdatavalid return 11 and do not count as polls.
- R6: While a data write is held, waitrequest stays high for `WRITE_CYCLES` consecutive cycles starting with the first cycle of the strobe. It is low in the next cycle, and the word is stored on that cycle's closing edge. Status reports 10 during programming.
- R7: Control bits [WP_LSB+2:WP_LSB] (default [26:24]) form the protect field; 000 unprotects and any other value protects. A write or erase attempted while protected leaves storage unchanged and clears its result bit (bit 3 or bit 4).
- R8: Control bits [22:20] name a sector to erase, and 111 means no erase. An accepted erase sets every word of that sector to 0xFFFFFFFF, leaves other sectors intact, and sets bit 4 to 1.
- R9: After an erase request, the first status poll returns 00. The erase then runs for `ERASE_CYCLES` cycles, during which polls return 01, and later polls return 00.
- R10: A data address at or beyond `NUM_SECTORS*SECTOR_WORDS` reads as zero with bit 2 cleared and writes nothing with bit 3 cleared. An erase request naming a sector at or beyond `NUM_SECTORS` clears bit 4 and starts no busy phase.
- R11: Control bits outside the protect and sector fields have no effect. Control writes and data reads that arrive while the sequencer is not in `S_IDLE` are dropped; a data write waits under waitrequest instead.
- R12: Reading control address 1 returns the protect field and sector field at their bit positions, with every other bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_addr | input | 1 | Control port address: 0 status, 1 control |
| ctl_rd | input | 1 | Control port read strobe |
| ctl_wr | input | 1 | Control port write strobe |
| ctl_wdata | input | 32 | Control port write data |
| ctl_rdata | output | 32 | Control port read data, registered |
| dat_addr | input | 17 | Data port word address |
| dat_rd | input | 1 | Data port read strobe, one cycle |
| dat_wr | input | 1 | Data port write strobe, held until accepted |
| dat_wdata | input | 32 | Data port write data |
| dat_rdata | output | 32 | Data port read data, valid with dat_rvalid |
| dat_waitreq | output | 1 | High while a held write is not yet accepted |
| dat_rvalid | output | 1 | One-cycle read data valid pulse |

## Verification
The assertions assume that the master keeps the write strobe, address and data steady until waitrequest falls. They also assume control-port reads and data reads are single-cycle pulses, and that one data operation is outstanding at a time. The stimulus drives every input on the falling clock edge. Every write task holds its strobe through the edge that follows waitrequest low, and each read is followed by the full three-poll status sequence before the next operation begins. Requests made deliberately while busy are limited to control writes and data reads, whose dropping the requirements define.

// File: rtl/flash_emu_pkg.sv
package flash_emu_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_WAIT,
        S_RD_POLL,
        S_WR_PROG,
        S_ER_ARM,
        S_ER_RUN
    } emu_state_t;

    localparam logic [1:0] BUSY_NONE  = 2'b00;
    localparam logic [1:0] BUSY_ERASE = 2'b01;
    localparam logic [1:0] BUSY_WRITE = 2'b10;
    localparam logic [1:0] BUSY_READ  = 2'b11;

    localparam int         SECT_LSB   = 20;
    localparam logic [2:0] SECT_NONE  = 3'b111;
    localparam int         POLLS_READ = 2;

endpackage

// File: rtl/flash_emu_store.sv
module flash_emu_store #(
    parameter int NUM_SECTORS  = 4,
    parameter int SECTOR_WORDS = 8,
    parameter int IDX_W        = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wr_data,
    input  logic             er_en,
    input  logic [2:0]       er_sector,
    output logic [31:0]      rd_data
);
    localparam int DEPTH = NUM_SECTORS * SECTOR_WORDS;

    logic [31:0] words [DEPTH];

    // Reset and erase both leave words in the all-ones state.
    always_ff @(posedge clk) begin
        for (int w = 0; w < DEPTH; w++) begin
            if (rst) begin
                words[w] <= '1;
            end else if (er_en && (er_sector == 3'(w / SECTOR_WORDS))) begin
                words[w] <= '1;
            end else if (wr_en && (idx == IDX_W'(w))) begin
                words[w] <= wr_data;
            end
        end
    end

    assign rd_data = words[idx];

endmodule

// File: rtl/flash_emu_seq.sv
module flash_emu_seq
    import flash_emu_pkg::*;
#(
    parameter int NUM_SECTORS  = 4,
    parameter int SECTOR_WORDS = 8,
    parameter int IDX_W        = 5,
    parameter int READ_LATENCY = 4,
    parameter int WRITE_CYCLES = 5,
    parameter int ERASE_CYCLES = 12,
    parameter int WP_LSB       = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_addr,
    input  logic             ctl_rd,
    input  logic             ctl_wr,
    input  logic [31:0]      ctl_wdata,
    output logic [31:0]      ctl_rdata,
    input  logic [16:0]      dat_addr,
    input  logic             dat_rd,
    input  logic             dat_wr,
    output logic [31:0]      dat_rdata,
    output logic             dat_waitreq,
    output logic             dat_rvalid,
    output logic             st_wr_en,
    output logic [IDX_W-1:0] st_idx,
    output logic             st_er_en,
    output logic [2:0]       st_er_sector,
    input  logic [31:0]      st_rd_data
);
    localparam int DEPTH  = NUM_SECTORS * SECTOR_WORDS;
    localparam int MAXC   = (ERASE_CYCLES > WRITE_CYCLES) ?
                            ((ERASE_CYCLES > READ_LATENCY) ? ERASE_CYCLES : READ_LATENCY) :
                            ((WRITE_CYCLES > READ_LATENCY) ? WRITE_CYCLES : READ_LATENCY);
    localparam int CNT_W  = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(READ_LATENCY - 1);
    localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WRITE_CYCLES - 1);
    localparam logic [CNT_W-1:0] ER_LOAD = CNT_W'(ERASE_CYCLES - 1);

    emu_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       poll_q;
    logic [2:0]       wp_q, sect_q, er_sect_q;
    logic             rd_ok_q, wr_ok_q, er_ok_q;
    logic             rvalid_q;
    logic [31:0]      rdata_q, ctl_rdata_q;
    logic [IDX_W-1:0] rd_idx_q;
    logic             rd_in_q;

    // Request decode
    logic [2:0]       new_wp, new_sect;
    logic             in_range, stat_rd, ctl_apply, er_req, er_valid;
    logic             erase_go, erase_reject, cnt_zero;
    logic [1:0]       busy_code;
    logic [31:0]      stat_view, ctl_view;

    assign new_wp       = ctl_wdata[WP_LSB +: 3];
    assign new_sect     = ctl_wdata[SECT_LSB +: 3];
    assign in_range     = dat_addr < 17'(DEPTH);
    assign stat_rd      = ctl_rd && !ctl_addr;
    assign cnt_zero     = cnt_q == '0;
    assign ctl_apply    = ctl_wr && ctl_addr && (state_q == S_IDLE);
    assign er_req       = ctl_apply && !dat_rd && !dat_wr && (new_sect != SECT_NONE);
    assign er_valid     = (new_wp == 3'b000) && (32'(new_sect) < NUM_SECTORS);
    assign erase_go     = er_req && er_valid;
    assign erase_reject = er_req && !er_valid;

    // Busy code as a status read would report it this cycle
    always_comb begin
        unique case (state_q)
            S_RD_WAIT: busy_code = BUSY_READ;
            S_RD_POLL: busy_code = (poll_q == 2'(POLLS_READ)) ? BUSY_NONE : BUSY_READ;
            S_WR_PROG: busy_code = BUSY_WRITE;
            S_ER_RUN:  busy_code = BUSY_ERASE;
            default:   busy_code = BUSY_NONE;
        endcase
    end

    assign stat_view = {27'b0, er_ok_q, wr_ok_q, rd_ok_q, busy_code};

    always_comb begin
        ctl_view                 = '0;
        ctl_view[WP_LSB +: 3]    = wp_q;
        ctl_view[SECT_LSB +: 3]  = sect_q;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (dat_rd)        state_d = S_RD_WAIT;
                else if (dat_wr)   state_d = S_WR_PROG;
                else if (erase_go) state_d = S_ER_ARM;
            end
            S_RD_WAIT: if (cnt_zero) state_d = S_RD_POLL;
            S_RD_POLL: if (stat_rd && poll_q == 2'(POLLS_READ)) state_d = S_IDLE;
            S_WR_PROG: if (!dat_wr || cnt_zero) state_d = S_IDLE;
            S_ER_ARM:  if (stat_rd) state_d = S_ER_RUN;
            S_ER_RUN:  if (cnt_zero) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Outputs, counters and reported results
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            poll_q      <= '0;
            wp_q        <= 3'b111;
            sect_q      <= SECT_NONE;
            er_sect_q   <= '0;
            rd_ok_q     <= 1'b1;
            wr_ok_q     <= 1'b1;
            er_ok_q     <= 1'b1;
            rvalid_q    <= 1'b0;
            rdata_q     <= '0;
            ctl_rdata_q <= '0;
            rd_idx_q    <= '0;
            rd_in_q     <= 1'b0;
        end else begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
            if (ctl_rd) ctl_rdata_q <= ctl_addr ? ctl_view : stat_view;
            if (ctl_apply) begin
                wp_q   <= new_wp;
                sect_q <= new_sect;
            end
            if (erase_reject) er_ok_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (dat_rd) begin
                        cnt_q    <= RD_LOAD;
                        rd_idx_q <= dat_addr[IDX_W-1:0];
                        rd_in_q  <= in_range;
                    end else if (dat_wr) begin
                        cnt_q <= WR_LOAD;
                    end else if (erase_go) begin
                        er_sect_q <= new_sect;
                    end
                end
                S_RD_WAIT: begin
                    if (cnt_zero) begin
                        rvalid_q <= 1'b1;
                        rdata_q  <= rd_in_q ? st_rd_data : '0;
                        rd_ok_q  <= rd_in_q;
                        poll_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                S_RD_POLL: if (stat_rd) poll_q <= poll_q + 1'b1;
                S_WR_PROG: begin
                    if (dat_wr && cnt_zero) wr_ok_q <= in_range && (wp_q == 3'b000);
                    else if (dat_wr)        cnt_q   <= cnt_q - 1'b1;
                end
                S_ER_ARM: if (stat_rd) cnt_q <= ER_LOAD;
                S_ER_RUN: begin
                    if (cnt_zero) er_ok_q <= 1'b1;
                    else          cnt_q   <= cnt_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign st_wr_en     = (state_q == S_WR_PROG) && dat_wr && cnt_zero &&
                          in_range && (wp_q == 3'b000);
    assign st_idx       = (state_q == S_WR_PROG) ? dat_addr[IDX_W-1:0] : rd_idx_q;
    assign st_er_en     = (state_q == S_ER_RUN) && cnt_zero;
    assign st_er_sector = er_sect_q;

    assign dat_waitreq  = dat_wr && !((state_q == S_WR_PROG) && cnt_zero);
    assign dat_rvalid   = rvalid_q;
    assign dat_rdata    = rdata_q;
    assign ctl_rdata    = ctl_rdata_q;

endmodule

// File: rtl/flash_ctl_emu.sv
module flash_ctl_emu #(
    parameter int NUM_SECTORS  = 4,
    parameter int SECTOR_WORDS = 8,
    parameter int READ_LATENCY = 4,
    parameter int WRITE_CYCLES = 5,
    parameter int ERASE_CYCLES = 12,
    parameter int WP_LSB       = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_addr,
    input  logic        ctl_rd,
    input  logic        ctl_wr,
    input  logic [31:0] ctl_wdata,
    output logic [31:0] ctl_rdata,
    input  logic [16:0] dat_addr,
    input  logic        dat_rd,
    input  logic        dat_wr,
    input  logic [31:0] dat_wdata,
    output logic [31:0] dat_rdata,
    output logic        dat_waitreq,
    output logic        dat_rvalid
);
    localparam int DEPTH = NUM_SECTORS * SECTOR_WORDS;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             st_wr_en, st_er_en;
    logic [IDX_W-1:0] st_idx;
    logic [2:0]       st_er_sector;
    logic [31:0]      st_rd_data;

    flash_emu_seq #(
        .NUM_SECTORS (NUM_SECTORS),
        .SECTOR_WORDS(SECTOR_WORDS),
        .IDX_W       (IDX_W),
        .READ_LATENCY(READ_LATENCY),
        .WRITE_CYCLES(WRITE_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES),
        .WP_LSB      (WP_LSB)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .ctl_addr    (ctl_addr),
        .ctl_rd      (ctl_rd),
        .ctl_wr      (ctl_wr),
        .ctl_wdata   (ctl_wdata),
        .ctl_rdata   (ctl_rdata),
        .dat_addr    (dat_addr),
        .dat_rd      (dat_rd),
        .dat_wr      (dat_wr),
        .dat_rdata   (dat_rdata),
        .dat_waitreq (dat_waitreq),
        .dat_rvalid  (dat_rvalid),
        .st_wr_en    (st_wr_en),
        .st_idx      (st_idx),
        .st_er_en    (st_er_en),
        .st_er_sector(st_er_sector),
        .st_rd_data  (st_rd_data)
    );

    flash_emu_store #(
        .NUM_SECTORS (NUM_SECTORS),
        .SECTOR_WORDS(SECTOR_WORDS),
        .IDX_W       (IDX_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (st_wr_en),
        .idx      (st_idx),
        .wr_data  (dat_wdata),
        .er_en    (st_er_en),
        .er_sector(st_er_sector),
        .rd_data  (st_rd_data)
    );

endmodule

// File: rtl/flash_ctl_emu_chk.sv
module flash_ctl_emu_chk (
    input logic        clk,
    input logic        rst,
    input logic        ctl_addr,
    input logic        ctl_rd,
    input logic [31:0] ctl_rdata,
    input logic        dat_wr,
    input logic        dat_waitreq,
    input logic        dat_rvalid,
    input logic [31:0] dat_rdata
);
    assert_status_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl_rd && !ctl_addr) |=> (ctl_rdata[31:5] == 27'b0));

    assert_ctl_rdata_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !ctl_rd |=> $stable(ctl_rdata));

    assert_rvalid_single_R4: assert property (@(posedge clk) disable iff (rst)
        dat_rvalid |=> !dat_rvalid);

    assert_rdata_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !dat_rvalid |-> (dat_rdata == 32'b0));

    assert_waitreq_needs_write_R6: assert property (@(posedge clk) disable iff (rst)
        !dat_wr |-> !dat_waitreq);
endmodule

bind flash_ctl_emu flash_ctl_emu_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .ctl_addr   (ctl_addr),
    .ctl_rd     (ctl_rd),
    .ctl_rdata  (ctl_rdata),
    .dat_wr     (dat_wr),
    .dat_waitreq(dat_waitreq),
    .dat_rvalid (dat_rvalid),
    .dat_rdata  (dat_rdata)
);

// File: tb/flash_ctl_emu_tb_top.sv
module flash_ctl_emu_tb_top;
    localparam int W_CYC = 5;
    localparam int E_CYC = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_addr = 1'b0, ctl_rd = 1'b0, ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic [16:0] dat_addr = '0;
    logic        dat_rd = 1'b0, dat_wr = 1'b0;
    logic [31:0] dat_wdata = '0;
    logic [31:0] dat_rdata;
    logic        dat_waitreq, dat_rvalid;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    flash_ctl_emu #(
        .NUM_SECTORS(4), .SECTOR_WORDS(8), .READ_LATENCY(4),
        .WRITE_CYCLES(W_CYC), .ERASE_CYCLES(E_CYC), .WP_LSB(24)
    ) dut_i (
        .clk(clk), .rst(rst),
        .ctl_addr(ctl_addr), .ctl_rd(ctl_rd), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .dat_addr(dat_addr), .dat_rd(dat_rd), .dat_wr(dat_wr),
        .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .dat_waitreq(dat_waitreq), .dat_rvalid(dat_rvalid)
    );

    // {address, data, expected success}
    localparam logic [49:0] VEC [6] = '{
        {17'd2,     32'hA5A5_0102, 1'b1},
        {17'd9,     32'h1357_9BDF, 1'b1},
        {17'd31,    32'h0000_0000, 1'b1},
        {17'd32,    32'hDEAD_BEEF, 1'b0},
        {17'h1FFFF, 32'h0BAD_F00D, 1'b0},
        {17'd16,    32'h8040_C020, 1'b1}
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ctl_read(input logic a, output logic [31:0] d);
        ctl_addr = a; ctl_rd = 1'b1;
        @(negedge clk);
        ctl_rd = 1'b0;
        d = ctl_rdata;
    endtask

    task automatic ctl_write(input logic [31:0] d);
        ctl_addr = 1'b1; ctl_wdata = d; ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic data_write(input logic [16:0] a, input logic [31:0] d, output int n);
        dat_addr = a; dat_wdata = d; dat_wr = 1'b1; n = 0;
        #1;
        for (int g = 0; g < 200 && dat_waitreq; g++) begin
            n++;
            @(negedge clk);
        end
        @(negedge clk);
        dat_wr = 1'b0;
    endtask

    task automatic poll_read_done(input logic ok, input string tag);
        logic [31:0] s;
        ctl_read(1'b0, s); chk(32'(s[1:0]), 32'd3, {tag, " R5 poll1 read-busy"});
        ctl_read(1'b0, s); chk(32'(s[1:0]), 32'd3, {tag, " R5 poll2 read-busy"});
        ctl_read(1'b0, s); chk(32'(s[1:0]), 32'd0, {tag, " R5 poll3 idle"});
        chk(32'(s[2]), 32'(ok), {tag, " R10 read result bit"});
    endtask

    task automatic data_read(input logic [16:0] a, input logic [31:0] exp, input logic ok,
                             input string tag);
        int hits;
        int at;
        logic [31:0] got;
        hits = 0; at = 0; got = '0;
        dat_addr = a; dat_rd = 1'b1;
        @(negedge clk);
        dat_rd = 1'b0;
        for (int i = 1; i <= 7; i++) begin
            if (i > 1) @(negedge clk);
            if (dat_rvalid) begin hits++; at = i; got = dat_rdata; end
        end
        chk(32'(hits), 32'd1, {tag, " R4 single valid pulse"});
        chk(32'(at), 32'd5, {tag, " R4 valid timing"});
        chk(got, exp, {tag, " R4 read data"});
        poll_read_done(ok, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] s;
        int n;
        int cnt;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(32'(dat_rvalid), 32'd0, "R1 rvalid low");
        chk(32'(dat_waitreq), 32'd0, "R1 waitreq low");
        ctl_read(1'b0, s); chk(s, 32'h0000_001C, "R1 status");
        ctl_read(1'b1, s); chk(s, 32'h0770_0000, "R1 R12 control readback");
        data_read(17'd5, 32'hFFFF_FFFF, 1'b1, "R1 erased word");

        // R7 write while protected
        data_write(17'd3, 32'h1234_5678, n);
        chk(32'(n), W_CYC, "R6 waitreq length protected");
        ctl_read(1'b0, s); chk(32'(s[3]), 32'd0, "R7 write result cleared");
        data_read(17'd3, 32'hFFFF_FFFF, 1'b1, "R7 storage unchanged");

        // Unprotect, unused bits all ones (R11)
        ctl_write(32'hF8FF_FFFF);
        ctl_read(1'b1, s); chk(s, 32'h0070_0000, "R11 R12 control fields only");

        // Vector table: write then read back
        for (int v = 0; v < 6; v++) begin
            data_write(VEC[v][49:33], VEC[v][32:1], n);
            chk(32'(n), W_CYC, "R6 waitreq length");
            ctl_read(1'b0, s); chk(32'(s[3]), 32'(VEC[v][0]), "R10 write result");
            data_read(VEC[v][49:33], VEC[v][0] ? VEC[v][32:1] : 32'h0, VEC[v][0], "R10 readback");
        end

        // R2 write busy code during programming
        dat_addr = 17'd20; dat_wdata = 32'hCAFE_0020; dat_wr = 1'b1;
        @(negedge clk);
        ctl_addr = 1'b0; ctl_rd = 1'b1;
        @(negedge clk);
        ctl_rd = 1'b0;
        chk(32'(ctl_rdata[1:0]), 32'd2, "R2 R6 write busy code");
        for (int g = 0; g < 50 && dat_waitreq; g++) @(negedge clk);
        @(negedge clk);
        dat_wr = 1'b0;
        ctl_read(1'b0, s); chk(32'(s[1:0]), 32'd0, "R2 idle after write");

        // R5 status read before valid is not counted
        dat_addr = 17'd20; dat_rd = 1'b1;
        @(negedge clk);
        dat_rd = 1'b0; ctl_addr = 1'b0; ctl_rd = 1'b1;
        @(negedge clk);
        ctl_rd = 1'b0;
        chk(32'(ctl_rdata[1:0]), 32'd3, "R2 R5 read busy before valid");
        repeat (6) @(negedge clk);
        poll_read_done(1'b1, "R5 early poll");

        // R8 R9 erase sector 1 with exact timing
        ctl_write(32'hF89F_FFFF);
        ctl_read(1'b0, s); chk(32'(s[1:0]), 32'd0, "R9 first poll idle");
        cnt = 0;
        ctl_read(1'b0, s);
        for (int g = 0; g < 100 && s[1:0] == 2'b01; g++) begin
            cnt++;
            ctl_read(1'b0, s);
        end
        chk(32'(cnt), E_CYC, "R9 erase busy polls");
        chk(32'(s[1:0]), 32'd0, "R9 idle after erase");
        chk(32'(s[4]), 32'd1, "R8 erase result");
        data_read(17'd9, 32'hFFFF_FFFF, 1'b1, "R8 sector1 erased");
        data_read(17'd2, 32'hA5A5_0102, 1'b1, "R8 sector0 intact");

        // R10 erase of a missing sector
        ctl_write(32'hF8DF_FFFF);
        ctl_read(1'b0, s);
        chk(32'(s[4]), 32'd0, "R10 erase result missing sector");
        chk(32'(s[1:0]), 32'd0, "R10 no busy phase");
        ctl_read(1'b1, s); chk(s, 32'h0050_0000, "R12 control readback");

        // R11 requests dropped while erasing sector 2
        ctl_write(32'hF8AF_FFFF);
        ctl_read(1'b0, s);
        ctl_write(32'hFFFF_FFFF);
        dat_addr = 17'd31; dat_rd = 1'b1;
        @(negedge clk);
        dat_rd = 1'b0;
        cnt = 0;
        for (int i = 0; i < 7; i++) begin
            if (dat_rvalid) cnt++;
            @(negedge clk);
        end
        chk(32'(cnt), 32'd0, "R11 read dropped while busy");
        ctl_read(1'b0, s);
        for (int g = 0; g < 100 && s[1:0] != 2'b00; g++) ctl_read(1'b0, s);
        chk(32'(s[4]), 32'd1, "R8 sector2 erase result");
        ctl_read(1'b1, s); chk(s, 32'h0020_0000, "R11 control write dropped");
        data_read(17'd16, 32'hFFFF_FFFF, 1'b1, "R8 sector2 erased");
        data_read(17'd31, 32'h0000_0000, 1'b1, "R8 sector3 intact");

        // R7 erase and write while protected
        ctl_write(32'hFC0F_FFFF);
        ctl_read(1'b0, s);
        chk(32'(s[4]), 32'd0, "R7 protected erase result");
        chk(32'(s[1:0]), 32'd0, "R7 protected erase no busy");
        data_read(17'd2, 32'hA5A5_0102, 1'b1, "R7 sector0 kept");
        data_write(17'd2, 32'h1111_1111, n);
        ctl_read(1'b0, s); chk(32'(s[3]), 32'd0, "R7 protected write result");
        data_read(17'd2, 32'hA5A5_0102, 1'b1, "R7 word kept");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule